// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a physical memory access made by a 64-bit hart may proceed. It holds sixteen protection entries. Each entry has an address register and an 8-bit configuration byte. The configuration bytes are packed eight to a 64-bit word. Software programs the entries through a single register write port. For every access, the block takes a physical address, an access kind and the current privilege level. It returns an allow flag together with the access-fault exception code that a trap unit would raise.

Each entry can be switched off or can describe a region in one of three ways:
- a range bounded by the previous entry's address and its own;
- one naturally aligned 4-byte word;
- a naturally aligned power-of-two block.

Entries are searched in index order, and the first entry that covers the address decides the result. Machine mode passes by default. Supervisor and user modes fail by default. A lock bit makes an entry bind machine mode too, and freezes that entry's registers until reset. The decision is combinational from the request inputs to the result outputs, so a pipeline can place it in whichever stage suits.

Top module: `pmp_guard`

## Requirements
- R1: A machine-mode access (privilege code 3) that no entry covers is allowed, with cause 0.
- R2: An access at any other privilege (0 user, 1 supervisor, 2 treated the same way) that no entry covers is denied.
- R3: Kind codes are 0 read, 1 write, 2 execute, and 3 is treated as a read. A denied access reports cause 5 for a read, 7 for a write and 1 for an execute. An allowed access reports cause 0.
- R4: An address register holds the physical address shifted right by two. It is written with `wr_cfg`=0, `wr_idx`=entry and the value in `wr_data[53:0]`. Entry i's config is byte i%8 (bits [8k+7:8k]) of config word i/8, written with `wr_cfg`=1 and `wr_idx`=word. In a config byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits [4:3] select the mode (0 off, 1 range, 2 single word, 3 power-of-two block) and bit 7 is lock. An entry whose mode is off covers nothing.
- R5: Range mode covers word addresses greater than or equal to the previous entry's register and strictly below this entry's register. For entry 0 the lower bound is zero.
- R6: Single-word mode covers exactly the 4-byte word whose shifted address equals the register.
- R7: In power-of-two mode, t trailing ones in the register select an aligned block of 2^(t+3) bytes.
- R8: When several entries cover an address, the lowest-numbered entry alone decides the result.
- R9: For a non-machine access, a covering entry allows the access only when the permission bit for its kind is set.
- R10: A machine access covered by an unlocked entry is allowed whatever its permission bits. A covering locked entry enforces its permission bits on machine mode too.
- R11: A locked entry ignores writes to both its config byte and its address register. The other bytes of the same config word are still written.
- R12: Reset clears every config byte and address register, which also removes all locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_cfg | input | 1 | 1 selects a packed config word, 0 selects an address register |
| wr_idx | input | 4 | Config word index or address register index |
| wr_data | input | 64 | Write data |
| chk_addr | input | 56 | Physical byte address of the access |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| chk_priv | input | 2 | Privilege: 3 machine, any other value is below machine |
| chk_allow | output | 1 | Access is permitted |
| chk_cause | output | 4 | Access-fault exception code, 0 when allowed |

## Verification
An entry register that holds a wrong value shows up as a wrong allow or cause at the very next check of an address near that entry's boundary. For this reason the vectors probe the first and last word inside each region and the first word outside it. A broken priority shows only where regions overlap, so overlapping blocks with different permissions are probed. A lock that does not hold is exposed as soon as an overwrite is attempted and the same address is checked again. Because the decision path has no register, every fault appears in the same cycle that the request is presented.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_EXEC  = 2'd2;

  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  localparam logic [3:0] CAUSE_NONE       = 4'd0;
  localparam logic [3:0] CAUSE_FETCH_ACC  = 4'd1;
  localparam logic [3:0] CAUSE_LOAD_ACC   = 4'd5;
  localparam logic [3:0] CAUSE_STORE_ACC  = 4'd7;

  typedef enum logic [1:0] {
    RGN_OFF   = 2'd0,
    RGN_RANGE = 2'd1,
    RGN_WORD  = 2'd2,
    RGN_POW2  = 2'd3
  } rgn_mode_e;

  typedef struct packed {
    logic      lock;
    logic [1:0] spare;
    rgn_mode_e mode;
    logic      px;
    logic      pw;
    logic      pr;
  } ent_cfg_t;

endpackage

// File: rtl/pmp_entry_bank.sv
module pmp_entry_bank
  import pmp_guard_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int AW      = 54,
  parameter int DW      = 64,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int PER_WD = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cfg,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output ent_cfg_t         cfg_q  [NUM_ENT],
  output logic [AW-1:0]    addr_q [NUM_ENT]
);

  // A locked entry refuses both register kinds; neighbours in the word still update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (!cfg_q[i].lock) begin
          if (wr_cfg && (wr_idx == IDX_W'(i / PER_WD)))
            cfg_q[i] <= ent_cfg_t'(wr_data[8*(i % PER_WD) +: 8]);
          if (!wr_cfg && (wr_idx == IDX_W'(i)))
            addr_q[i] <= wr_data[AW-1:0];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_lock_chk
    p_lock_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[g].lock |=> $stable(addr_q[g]));
    p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[g].lock |=> (cfg_q[g].lock && $stable(cfg_q[g])));
  end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_guard_pkg::*;
#(
  parameter int AW = 54
) (
  input  rgn_mode_e     mode,
  input  logic [AW-1:0] reg_this,
  input  logic [AW-1:0] reg_prev,
  input  logic [AW-1:0] word_addr,
  output logic          hit
);

  function automatic logic in_range(input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                                    input logic [AW-1:0] a);
    return (a >= lo) && (a < hi);
  endfunction

  // reg ^ (reg + 1) sets bit t and every bit below it; those bits are "don't care".
  function automatic logic in_pow2(input logic [AW-1:0] r, input logic [AW-1:0] a);
    logic [AW-1:0] care_n;
    care_n = r ^ (r + AW'(1));
    return ((a ^ r) & ~care_n) == '0;
  endfunction

  always_comb begin
    unique case (mode)
      RGN_RANGE: hit = in_range(reg_prev, reg_this, word_addr);
      RGN_WORD:  hit = (word_addr == reg_this);
      RGN_POW2:  hit = in_pow2(reg_this, word_addr);
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_priority_decide.sv
module pmp_priority_decide
  import pmp_guard_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  logic [NUM_ENT-1:0] hit,
  input  logic [NUM_ENT-1:0] lock,
  input  logic [NUM_ENT-1:0] perm_r,
  input  logic [NUM_ENT-1:0] perm_w,
  input  logic [NUM_ENT-1:0] perm_x,
  input  logic [1:0]         priv,
  input  logic [1:0]         kind,
  output logic [NUM_ENT-1:0] winner,
  output logic               allow,
  output logic [3:0]         cause
);

  function automatic logic kind_ok(input logic [1:0] k, input logic r, input logic w,
                                   input logic x);
    case (k)
      KIND_WRITE: return w;
      KIND_EXEC:  return x;
      default:    return r;
    endcase
  endfunction

  logic is_mach;
  assign is_mach = (priv == PRIV_MACHINE);

  // Walk from the highest index down so the lowest covering entry is the last to write.
  always_comb begin
    winner = '0;
    allow  = is_mach;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        winner    = '0;
        winner[i] = 1'b1;
        allow     = (is_mach && !lock[i]) || kind_ok(kind, perm_r[i], perm_w[i], perm_x[i]);
      end
    end
  end

  always_comb begin
    if (allow)                 cause = CAUSE_NONE;
    else if (kind == KIND_EXEC)  cause = CAUSE_FETCH_ACC;
    else if (kind == KIND_WRITE) cause = CAUSE_STORE_ACC;
    else                         cause = CAUSE_LOAD_ACC;
  end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
  import pmp_guard_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int PA_BITS = 56,
  parameter int DW      = 64,
  localparam int AW     = PA_BITS - 2,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_cfg,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic [PA_BITS-1:0] chk_addr,
  input  logic [1:0]         chk_kind,
  input  logic [1:0]         chk_priv,
  output logic               chk_allow,
  output logic [3:0]         chk_cause
);

  ent_cfg_t           cfg_q  [NUM_ENT];
  logic [AW-1:0]      addr_q [NUM_ENT];
  logic [NUM_ENT-1:0] hit_vec, lock_vec, r_vec, w_vec, x_vec, winner_vec;
  logic [AW-1:0]      word_addr;
  logic [1:0]         unused_byte_off;

  assign word_addr       = chk_addr[PA_BITS-1:2];
  assign unused_byte_off = chk_addr[1:0];

  pmp_entry_bank #(.NUM_ENT(NUM_ENT), .AW(AW), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg_q(cfg_q), .addr_q(addr_q)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [AW-1:0] lower;
    logic [1:0]    unused_spare;
    if (g == 0) begin : g_base
      assign lower = '0;
    end else begin : g_chain
      assign lower = addr_q[g-1];
    end
    assign unused_spare = cfg_q[g].spare;
    assign lock_vec[g]  = cfg_q[g].lock;
    assign r_vec[g]     = cfg_q[g].pr;
    assign w_vec[g]     = cfg_q[g].pw;
    assign x_vec[g]     = cfg_q[g].px;

    pmp_region_match #(.AW(AW)) u_match (
      .mode(cfg_q[g].mode), .reg_this(addr_q[g]), .reg_prev(lower),
      .word_addr(word_addr), .hit(hit_vec[g])
    );
  end

  pmp_priority_decide #(.NUM_ENT(NUM_ENT)) u_decide (
    .hit(hit_vec), .lock(lock_vec), .perm_r(r_vec), .perm_w(w_vec), .perm_x(x_vec),
    .priv(chk_priv), .kind(chk_kind), .winner(winner_vec),
    .allow(chk_allow), .cause(chk_cause)
  );

  p_mach_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0 && chk_priv == PRIV_MACHINE) |-> chk_allow);
  p_low_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0 && chk_priv != PRIV_MACHINE) |-> !chk_allow);
  p_allow_no_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_allow |-> (chk_cause == CAUSE_NONE));
  p_exec_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_allow && chk_kind == KIND_EXEC) |-> (chk_cause == CAUSE_FETCH_ACC));
  p_store_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_allow && chk_kind == KIND_WRITE) |-> (chk_cause == CAUSE_STORE_ACC));
  p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner_vec) && ((winner_vec != '0) == (hit_vec != '0)));
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (winner_vec != '0) |-> (((winner_vec - 1'b1) & hit_vec) == '0));
  p_lock_binds_mach_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((winner_vec & lock_vec) != '0 && chk_kind == KIND_WRITE
      && (winner_vec & w_vec) == '0) |-> !chk_allow);

endmodule

// File: tb/sim_pmp_guard.sv
module sim_pmp_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_cfg = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [55:0] chk_addr = '0;
  logic [1:0]  chk_kind = '0;
  logic [1:0]  chk_priv = '0;
  logic        chk_allow;
  logic [3:0]  chk_cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
    .wr_data(wr_data), .chk_addr(chk_addr), .chk_kind(chk_kind), .chk_priv(chk_priv),
    .chk_allow(chk_allow), .chk_cause(chk_cause)
  );

  typedef struct packed {
    logic [1:0]  priv;
    logic [1:0]  kind;
    logic [55:0] addr;
    logic        allow;
    logic [3:0]  cause;
    logic [7:0]  req;
  } vec_t;

  // priv 0 user, 1 supervisor, 3 machine; kind 0 rd, 1 wr, 2 ex, 3 rd
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 56'h8000_0000,   1'b1, 4'd0, 8'd5},  // R5 lower bound inclusive
    '{2'd0, 2'd0, 56'hFFFF_FFFC,   1'b1, 4'd0, 8'd5},  // R5 last word
    '{2'd0, 2'd0, 56'h1_0000_0000, 1'b0, 4'd5, 8'd5},  // R5 upper exclusive
    '{2'd0, 2'd0, 56'h7FFF_FFFC,   1'b0, 4'd5, 8'd5},  // R5 below range
    '{2'd0, 2'd1, 56'h8000_0000,   1'b0, 4'd7, 8'd9},  // R9 no write perm
    '{2'd0, 2'd2, 56'h8000_0000,   1'b0, 4'd1, 8'd3},  // R3 fetch fault
    '{2'd0, 2'd1, 56'h2000,        1'b1, 4'd0, 8'd6},  // R6 word hit
    '{2'd0, 2'd1, 56'h2004,        1'b0, 4'd7, 8'd6},  // R6 next word misses
    '{2'd0, 2'd2, 56'h4000,        1'b1, 4'd0, 8'd7},  // R7 64B block base
    '{2'd0, 2'd2, 56'h403C,        1'b1, 4'd0, 8'd7},  // R7 64B block top
    '{2'd0, 2'd0, 56'h4000,        1'b0, 4'd5, 8'd8},  // R8 entry3 beats entry4
    '{2'd0, 2'd0, 56'h4040,        1'b1, 4'd0, 8'd8},  // R8 only entry4 covers
    '{2'd0, 2'd2, 56'h40FC,        1'b1, 4'd0, 8'd7},  // R7 256B block top
    '{2'd0, 2'd0, 56'h4100,        1'b0, 4'd5, 8'd7},  // R7 past block
    '{2'd3, 2'd1, 56'h6000,        1'b0, 4'd7, 8'd10}, // R10 lock binds machine
    '{2'd3, 2'd0, 56'h6000,        1'b1, 4'd0, 8'd10}, // R10 locked read ok
    '{2'd3, 2'd1, 56'h2004,        1'b1, 4'd0, 8'd1},  // R1 machine default
    '{2'd1, 2'd1, 56'h2004,        1'b0, 4'd7, 8'd2},  // R2 supervisor default
    '{2'd3, 2'd0, 56'h4000,        1'b1, 4'd0, 8'd10}, // R10 unlocked override
    '{2'd0, 2'd0, 56'hC000,        1'b0, 4'd5, 8'd4},  // R4 mode off covers nothing
    '{2'd0, 2'd3, 56'h8000_0000,   1'b1, 4'd0, 8'd3}   // R3 kind 3 acts as read
  };

  task automatic write_reg(input logic cfg, input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_cfg = cfg; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [1:0] pv, input logic [1:0] kd, input logic [55:0] a,
                       input logic exp_allow, input logic [3:0] exp_cause, input string tag);
    @(negedge clk);
    chk_priv = pv; chk_kind = kd; chk_addr = a;
    #1;
    checks++;
    if (chk_allow !== exp_allow || chk_cause !== exp_cause) begin
      failures++;
      $display("FAIL %s addr=%h allow=%b cause=%0d expected allow=%b cause=%0d",
               tag, a, chk_allow, chk_cause, exp_allow, exp_cause);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state: nothing configured
    probe(2'd0, 2'd0, 56'h8000_0000, 1'b0, 4'd5, "R12 user read after reset");
    probe(2'd3, 2'd1, 56'h6000,      1'b1, 4'd0, "R12 machine write after reset");

    // R4 address registers hold byte address >> 2
    write_reg(1'b0, 4'd0, 64'h2000_0000);
    write_reg(1'b0, 4'd1, 64'h4000_0000);
    write_reg(1'b0, 4'd2, 64'h800);
    write_reg(1'b0, 4'd3, 64'h1007);
    write_reg(1'b0, 4'd4, 64'h101F);
    write_reg(1'b0, 4'd5, 64'h1800);
    write_reg(1'b0, 4'd6, 64'h3001);
    // bytes: e0 off, e1 range R, e2 word W, e3 pow2 X, e4 pow2 RWX, e5 locked word R
    write_reg(1'b1, 4'd0, 64'h0000_911F_1C12_0900);

    for (int i = 0; i < NV; i++)
      probe(VECS[i].priv, VECS[i].kind, VECS[i].addr, VECS[i].allow, VECS[i].cause,
            $sformatf("R%0d vector %0d", VECS[i].req, i));

    // R11 locked address register refuses a write
    write_reg(1'b0, 4'd5, 64'h0);
    probe(2'd3, 2'd1, 56'h6000, 1'b0, 4'd7, "R11 locked address kept");
    probe(2'd3, 2'd1, 56'h0,    1'b1, 4'd0, "R11 no region moved to zero");
    // R11 locked byte kept, neighbour byte 6 (pow2 R) written
    write_reg(1'b1, 4'd0, 64'h0019_001F_1C12_0900);
    probe(2'd0, 2'd0, 56'hC00C, 1'b1, 4'd0, "R11 neighbour byte written");
    probe(2'd3, 2'd1, 56'h6000, 1'b0, 4'd7, "R11 locked config kept");

    // R5 entry 0 range starts at zero (execute only)
    write_reg(1'b1, 4'd0, 64'h0019_001F_1C12_090C);
    probe(2'd0, 2'd2, 56'h0,           1'b1, 4'd0, "R5 entry0 zero bound");
    probe(2'd0, 2'd2, 56'h7FFF_FFFC,   1'b1, 4'd0, "R5 entry0 top word");
    probe(2'd0, 2'd0, 56'h2000,        1'b0, 4'd5, "R8 entry0 shadows later entries");
    probe(2'd0, 2'd2, 56'h8000_0000,   1'b0, 4'd1, "R9 entry1 lacks execute");

    // R12 reset clears locks and config
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe(2'd3, 2'd1, 56'h6000,      1'b1, 4'd0, "R12 lock cleared by reset");
    probe(2'd0, 2'd0, 56'h8000_0000, 1'b0, 4'd5, "R12 range cleared by reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule